// File: doc/BRIEF.md
# Luma Capture Write Controller

This block sits between a digital video decoder and a host processor. It runs on the decoder's pixel clock, follows the line sync, frame sync and field flag to find where a frame starts and where each line starts, and picks the luminance bytes out of the interleaved 4:2:2 byte stream. It drops the chroma bytes. It crops a window of IMG_W by IMG_H grey samples (256 by 256 by default) and writes each kept byte into an on-chip buffer FIFO.

The processor does not take one interrupt per pixel. It receives a block request (`dma_req`) whenever the buffer holds at least half its depth. It then drains the buffer by holding its chip-enable and its read strobe low together. One byte leaves the FIFO on each clock edge with both strobes low.

A capture starts on a frame sync edge that arrives during the even field. It skips a programmable number of lines and a programmable number of luminance samples per line. Once the last sample of the window is written, the block reports a finished frame and writes nothing more until the next capture starts. A write that finds the buffer full is dropped and sets a sticky flag that the processor clears.

Top module: `luma_capture_top`

## Requirements
- R1: While `vid_hs` is low, the bytes after the fall of `vid_hs` are numbered 0, 1, 2, … Even-numbered bytes are chroma and are never written. Odd-numbered bytes are luminance samples, and luminance sample k of a line is byte 2k+1.
- R2: Within a captured line, luminance samples k < `cfg_hoff` are skipped, samples `cfg_hoff` to `cfg_hoff`+IMG_W-1 are written, and later samples are skipped.
- R3: After arming, the first rising edge of `vid_hs` opens line 0 and each later rising edge opens the next line. Lines below `cfg_voff` are skipped, lines `cfg_voff` to `cfg_voff`+IMG_H-1 are captured, and the bytes leave the FIFO in arrival order.
- R4: A rising edge of `vid_vs` arms a capture only while `vid_fld` is 0 (even field). An edge with `vid_fld` at 1 changes nothing, including during a capture in progress and after a finished frame.
- R5: `frame_done` rises in the cycle after the last sample of the window (line `cfg_voff`+IMG_H-1, sample `cfg_hoff`+IMG_W-1) is presented. It stays high until the next arming edge, and no byte is written while it is high.
- R6: `dma_req` is high exactly while the FIFO holds at least FIFO_DEPTH/2 bytes.
- R7: On each rising clock edge with `host_ce_n` and `host_re_n` both low and the FIFO not empty, the oldest byte is removed and appears on `host_rdata` after that edge. `host_rdata` keeps that value until the next removal.
- R8: With only one of `host_ce_n` and `host_re_n` low, nothing is removed.
- R9: A read strobe on an empty FIFO removes nothing and leaves `host_rdata` unchanged.
- R10: A write that finds the FIFO full is dropped and sets `ovf_flag`. The flag stays set until `ovf_clr` is high on a clock edge.
- R11: After reset the FIFO is empty, and `dma_req`, `frame_done`, `ovf_flag` and `host_rdata` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock from the decoder |
| rst_n | input | 1 | Synchronous active-low reset |
| vid_hs | input | 1 | Line sync, active high |
| vid_vs | input | 1 | Frame sync, active high |
| vid_fld | input | 1 | Field flag, 0 for even field |
| vid_data | input | 8 | Interleaved 4:2:2 byte stream |
| cfg_hoff | input | HOFF_W | Luminance samples skipped at the start of each line |
| cfg_voff | input | VOFF_W | Lines skipped after arming |
| host_ce_n | input | 1 | Processor chip-enable, active low |
| host_re_n | input | 1 | Processor read strobe, active low |
| host_rdata | output | 8 | Last byte removed from the FIFO |
| dma_req | output | 1 | Block request, high while the FIFO is at least half full |
| frame_done | output | 1 | Capture window finished |
| ovf_flag | output | 1 | Sticky flag for dropped writes |
| ovf_clr | input | 1 | Clears `ovf_flag` |

## Verification
A byte-phase error swaps luminance for chroma at the output. A line-counter or column-counter error shifts the cropped window. Either one shows up on `host_rdata` at the first drained byte of the affected line, because each drained byte is compared against the byte the bench drove at that position. A write-pointer or occupancy error shows up on `dma_req` at the single removal that should carry the FIFO across its half mark. An arming or termination fault shows up on `frame_done` one cycle after the last window sample, or later as extra or missing bytes when the next frame is drained.

// File: rtl/luma_cap_pkg.sv
// Shared types for the luma capture write controller.
// Assumes a single clock domain: the decoder pixel clock.
package luma_cap_pkg;
    typedef logic [7:0] byte_t;

    typedef enum logic [1:0] {
        CAP_IDLE = 2'd0,
        CAP_RUN  = 2'd1,
        CAP_DONE = 2'd2
    } cap_state_e;
endpackage

// File: rtl/luma_cap_framer.sv
// Sync decoder and crop unit.
// Follows line and frame sync, keeps only the luminance bytes of a 4:2:2
// stream, and presents the kept bytes of the crop window as registered writes.
// Assumes sync and data are already synchronous to clk and that line sync
// and frame sync never rise in the same cycle.
module luma_cap_framer
    import luma_cap_pkg::*;
#(
    parameter int IMG_W  = 256,
    parameter int IMG_H  = 256,
    parameter int HOFF_W = 10,
    parameter int VOFF_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hs,
    input  logic              vs,
    input  logic              fld,
    input  byte_t             pix,
    input  logic [HOFF_W-1:0] hoff,
    input  logic [VOFF_W-1:0] voff,
    output logic              wr_vld,
    output byte_t             wr_byte,
    output logic              frame_done
);
    localparam int HSPAN = (1 << HOFF_W) + IMG_W;
    localparam int VSPAN = (1 << VOFF_W) + IMG_H;
    localparam int POS_W = $clog2((HSPAN > VSPAN) ? HSPAN : VSPAN) + 1;
    localparam logic [POS_W-1:0] POS_MAX = '1;

    cap_state_e       state;
    logic             hs_q, vs_q;
    logic             started;
    logic             phase;
    logic [POS_W-1:0] line_idx;
    logic [POS_W-1:0] y_idx;
    logic [POS_W-1:0] row_lo, row_hi, col_lo, col_hi;
    logic             hs_rise, arm, in_rows, in_cols, take, last;

    // Window bounds, widened to the counter width.
    always_comb begin
        row_lo = POS_W'(voff);
        row_hi = POS_W'(voff) + POS_W'(IMG_H);
        col_lo = POS_W'(hoff);
        col_hi = POS_W'(hoff) + POS_W'(IMG_W);
    end

    // Edge detection and the keep decision for the current byte.
    always_comb begin
        hs_rise = hs && !hs_q;
        arm     = vs && !vs_q && !fld;
        in_rows = started && (line_idx >= row_lo) && (line_idx < row_hi);
        in_cols = (y_idx >= col_lo) && (y_idx < col_hi);
        take    = (state == CAP_RUN) && !hs && phase && in_rows && in_cols;
        last    = take && (line_idx == row_hi - 1'b1) && (y_idx == col_hi - 1'b1);
    end

    // Sync edge history.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hs_q <= 1'b0;
            vs_q <= 1'b0;
        end else begin
            hs_q <= hs;
            vs_q <= vs;
        end
    end

    // Capture state: arming on an even-field frame sync, finishing on the last sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= CAP_IDLE;
        end else if (arm) begin
            state <= CAP_RUN;
        end else if (last) begin
            state <= CAP_DONE;
        end
    end

    // Line counter: the first line sync after arming opens line 0.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            started  <= 1'b0;
            line_idx <= '0;
        end else if (arm) begin
            started  <= 1'b0;
            line_idx <= '0;
        end else if (hs_rise) begin
            if (!started) begin
                started  <= 1'b1;
                line_idx <= '0;
            end else if (line_idx != POS_MAX) begin
                line_idx <= line_idx + 1'b1;
            end
        end
    end

    // Byte phase and luminance index within the line, cleared while sync is high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= 1'b0;
            y_idx <= '0;
        end else if (hs) begin
            phase <= 1'b0;
            y_idx <= '0;
        end else begin
            phase <= !phase;
            if (phase && y_idx != POS_MAX) begin
                y_idx <= y_idx + 1'b1;
            end
        end
    end

    // Registered write toward the FIFO.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_vld  <= 1'b0;
            wr_byte <= '0;
        end else begin
            wr_vld  <= take;
            wr_byte <= take ? pix : wr_byte;
        end
    end

    assign frame_done = (state == CAP_DONE);

    // No write may follow a cycle of line sync (R1).
    assert_hs_nowrite_R1: assert property (@(posedge clk) disable iff (!rst_n)
        hs |=> !wr_vld);
    // Luminance bytes alternate with chroma, so writes never come back to back (R1).
    assert_alt_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
        wr_vld |=> !wr_vld);
    // A finished frame writes nothing (R5).
    assert_done_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> !wr_vld);
    // An odd-field frame sync never starts a capture (R4).
    assert_odd_no_arm_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (vs && !vs_q && fld && state != CAP_RUN) |=> $stable(state));
endmodule

// File: rtl/luma_cap_rd_decode.sv
// Host read decode.
// Combines the processor chip-enable and read strobe (both active low) into
// a removal request, gated by FIFO emptiness.
// Assumes the strobes are synchronous to clk.
module luma_cap_rd_decode (
    input  logic ce_n,
    input  logic re_n,
    input  logic empty,
    output logic pop
);
    // Removal happens only with both strobes low and data present.
    always_comb begin
        pop = !ce_n && !re_n && !empty;
    end
endmodule

// File: rtl/luma_cap_fifo.sv
// Single-clock buffer FIFO with half-full block request and sticky overflow.
// Writes come from the framer, reads from the host decode.
// Assumes DEPTH is a power of two.
module luma_cap_fifo
    import luma_cap_pkg::*;
#(
    parameter int DEPTH = 1024
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  wr_vld,
    input  byte_t wr_byte,
    input  logic  pop,
    input  logic  ovf_clr,
    output logic  empty,
    output byte_t rd_data,
    output logic  half_req,
    output logic  ovf
);
    localparam int AW    = $clog2(DEPTH);
    localparam int CW    = AW + 1;
    localparam int HALF  = DEPTH / 2;

    byte_t         mem [DEPTH];
    logic [AW-1:0] wptr, rptr;
    logic [CW-1:0] count;
    logic          full, wr_ok;

    // Occupancy flags and write acceptance.
    always_comb begin
        full     = (count == CW'(DEPTH));
        empty    = (count == '0);
        wr_ok    = wr_vld && !full;
        half_req = (count >= CW'(HALF));
    end

    // Storage write.
    always_ff @(posedge clk) begin
        if (wr_ok) begin
            mem[wptr] <= wr_byte;
        end
    end

    // Pointers and occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (wr_ok) wptr <= wptr + 1'b1;
            if (pop)   rptr <= rptr + 1'b1;
            case ({wr_ok, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    // Read register holds the last removed byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data <= '0;
        end else if (pop) begin
            rd_data <= mem[rptr];
        end
    end

    // Sticky overflow; a new drop wins over a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovf <= 1'b0;
        end else if (wr_vld && full) begin
            ovf <= 1'b1;
        end else if (ovf_clr) begin
            ovf <= 1'b0;
        end
    end

    // Occupancy never exceeds the depth (R10).
    assert_count_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));
    // A write into a full buffer leaves the flag set (R10).
    assert_ovf_set_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_vld && full) |=> ovf);
    // The request falls only after a removal (R6).
    assert_req_fall_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(half_req) |-> $past(pop));
    // The request rises only after an accepted write (R6).
    assert_req_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(half_req) |-> $past(wr_ok));
    // Reading an empty buffer leaves it empty (R9).
    assert_empty_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && !wr_vld) |=> empty);
    // Read data holds between removals (R7).
    assert_rd_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !pop |=> $stable(rd_data));
endmodule

// File: rtl/luma_capture_top.sv
// Luma capture write controller top level.
// Decodes sync, crops luminance into a buffer FIFO, requests a block transfer
// at half full, and serves host reads through the chip-enable/read-strobe decode.
// Assumes all inputs are synchronous to the pixel clock.
module luma_capture_top
    import luma_cap_pkg::*;
#(
    parameter int IMG_W      = 256,
    parameter int IMG_H      = 256,
    parameter int FIFO_DEPTH = 1024,
    parameter int HOFF_W     = 10,
    parameter int VOFF_W     = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              vid_hs,
    input  logic              vid_vs,
    input  logic              vid_fld,
    input  logic [7:0]        vid_data,
    input  logic [HOFF_W-1:0] cfg_hoff,
    input  logic [VOFF_W-1:0] cfg_voff,
    input  logic              host_ce_n,
    input  logic              host_re_n,
    output logic [7:0]        host_rdata,
    output logic              dma_req,
    output logic              frame_done,
    output logic              ovf_flag,
    input  logic              ovf_clr
);
    logic  wr_vld, pop, empty;
    byte_t wr_byte;

    luma_cap_framer #(
        .IMG_W (IMG_W),
        .IMG_H (IMG_H),
        .HOFF_W(HOFF_W),
        .VOFF_W(VOFF_W)
    ) u_framer (
        .clk       (clk),
        .rst_n     (rst_n),
        .hs        (vid_hs),
        .vs        (vid_vs),
        .fld       (vid_fld),
        .pix       (vid_data),
        .hoff      (cfg_hoff),
        .voff      (cfg_voff),
        .wr_vld    (wr_vld),
        .wr_byte   (wr_byte),
        .frame_done(frame_done)
    );

    luma_cap_rd_decode u_rd (
        .ce_n (host_ce_n),
        .re_n (host_re_n),
        .empty(empty),
        .pop  (pop)
    );

    luma_cap_fifo #(
        .DEPTH(FIFO_DEPTH)
    ) u_fifo (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_vld  (wr_vld),
        .wr_byte (wr_byte),
        .pop     (pop),
        .ovf_clr (ovf_clr),
        .empty   (empty),
        .rd_data (host_rdata),
        .half_req(dma_req),
        .ovf     (ovf_flag)
    );

    // A strobe with one side high never changes the read data (R8).
    assert_partial_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (host_ce_n || host_re_n) |=> $stable(host_rdata));
endmodule

// File: tb/tb_luma_capture_top.sv
`timescale 1ns/1ps
module tb_luma_capture_top;
    localparam int W = 8;
    localparam int H = 4;
    localparam int D = 32;
    localparam int HW = 4;
    localparam int VW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          vid_hs = 1'b0, vid_vs = 1'b0, vid_fld = 1'b0;
    logic [7:0]    vid_data = 8'h00;
    logic [HW-1:0] cfg_hoff = '0;
    logic [VW-1:0] cfg_voff = '0;
    logic          host_ce_n = 1'b1, host_re_n = 1'b1, ovf_clr = 1'b0;
    logic [7:0]    host_rdata;
    logic          dma_req, frame_done, ovf_flag;

    luma_capture_top #(.IMG_W(W), .IMG_H(H), .FIFO_DEPTH(D), .HOFF_W(HW), .VOFF_W(VW)) dut (
        .clk(clk), .rst_n(rst_n), .vid_hs(vid_hs), .vid_vs(vid_vs), .vid_fld(vid_fld),
        .vid_data(vid_data), .cfg_hoff(cfg_hoff), .cfg_voff(cfg_voff),
        .host_ce_n(host_ce_n), .host_re_n(host_re_n), .host_rdata(host_rdata),
        .dma_req(dma_req), .frame_done(frame_done), .ovf_flag(ovf_flag), .ovf_clr(ovf_clr)
    );

    always #2.5 clk = ~clk;

    int   total = 0, bad = 0;
    bit   finished = 0;
    logic [7:0] exp_q[$];
    int   armed = 0, started = 0, line = 0, done_m = 0, ovf_m = 0;
    int   hoff_m = 0, voff_m = 0;
    logic [7:0] last_rd = 8'h00;

    task automatic chk(input string req, input int act, input int expv);
        total++;
        if (act !== expv) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    // Bench rule for the keep decision of byte b in the current line.
    function automatic bit keep_byte(input int b);
        int y = b / 2;
        return (b % 2 == 1) && armed != 0 && done_m == 0 && started != 0 &&
               line >= voff_m && line < voff_m + H && y >= hoff_m && y < hoff_m + W;
    endfunction

    task automatic set_offsets(input int ho, input int vo);
        hoff_m = ho; voff_m = vo;
        cfg_hoff = HW'(ho); cfg_voff = VW'(vo);
    endtask

    task automatic do_vs(input bit f);
        @(negedge clk); vid_vs = 1'b1; vid_fld = f;
        if (!f) begin armed = 1; started = 0; line = 0; done_m = 0; end
        @(negedge clk); @(negedge clk); vid_vs = 1'b0; vid_fld = 1'b0;
    endtask

    task automatic do_line(input int nbytes);
        @(negedge clk); vid_hs = 1'b1;
        if (started != 0) line++; else begin started = 1; line = 0; end
        @(negedge clk);
        for (int b = 0; b < nbytes; b++) begin
            @(negedge clk);
            vid_hs = 1'b0;
            vid_data = 8'($urandom);
            if (keep_byte(b)) begin
                bit lastb = (line == voff_m + H - 1) && (b / 2 == hoff_m + W - 1);
                if (exp_q.size() < D) exp_q.push_back(vid_data); else ovf_m = 1;
                if (lastb) begin
                    chk("R5 done low before last sample", int'(frame_done), 0);
                    done_m = 1;
                    @(negedge clk);
                    vid_data = 8'($urandom);
                    chk("R5 done one cycle after last sample", int'(frame_done), 1);
                    b++;
                end
            end
        end
    endtask

    function automatic int line_len();
        return 2 * (hoff_m + W) + int'($urandom_range(0, 12));
    endfunction

    task automatic frame(input int extra_lines, input bit odd_mid);
        do_vs(1'b0);
        for (int l = 0; l < voff_m + H + extra_lines; l++) begin
            do_line(line_len());
            if (odd_mid && l == 0) do_vs(1'b1);
        end
        repeat (3) @(negedge clk);
    endtask

    task automatic pop_one(input string req);
        logic [7:0] e;
        @(negedge clk); host_ce_n = 1'b0; host_re_n = 1'b0;
        @(negedge clk); host_ce_n = 1'b1; host_re_n = 1'b1;
        e = exp_q.pop_front();
        chk(req, int'(host_rdata), int'(e));
        chk("R6 request after removal", int'(dma_req), int'(exp_q.size() >= D / 2));
        last_rd = host_rdata;
    endtask

    task automatic drain(input string req);
        while (exp_q.size() > 0) pop_one(req);
    endtask

    initial begin
        #(5.0 * 150000);
        if (!finished) begin
            bad++; total++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R11 rdata", int'(host_rdata), 0);
        chk("R11 dma_req", int'(dma_req), 0);
        chk("R11 frame_done", int'(frame_done), 0);
        chk("R11 ovf", int'(ovf_flag), 0);

        // Odd-field arm while idle, then a directed frame with mid-capture odd sync.
        set_offsets(2, 1);
        do_vs(1'b1);
        do_line(24); do_line(24);
        repeat (3) @(negedge clk);
        chk("R4 odd field captures nothing", int'(dma_req), 0);
        frame(2, 1'b1);
        chk("R6 full buffer raises request", int'(dma_req), 1);
        chk("R10 no overflow on exact fill", int'(ovf_flag), ovf_m);
        do_vs(1'b1);
        repeat (2) @(negedge clk);
        chk("R4 odd sync keeps frame_done", int'(frame_done), 1);

        // Overflow: another even frame into a full buffer.
        set_offsets(0, 0);
        frame(0, 1'b0);
        chk("R10 overflow set", int'(ovf_flag), 1);
        repeat (2) @(negedge clk);
        chk("R10 overflow sticky", int'(ovf_flag), 1);
        @(negedge clk); ovf_clr = 1'b1;
        @(negedge clk); ovf_clr = 1'b0;
        chk("R10 overflow cleared", int'(ovf_flag), 0);

        // Partial strobes remove nothing.
        pop_one("R7 first byte");
        @(negedge clk); host_ce_n = 1'b0; host_re_n = 1'b1;
        @(negedge clk); host_ce_n = 1'b1; host_re_n = 1'b0;
        @(negedge clk); host_re_n = 1'b1;
        chk("R8 partial strobe keeps rdata", int'(host_rdata), int'(last_rd));
        drain("R1 R2 R3 R7 drained byte");

        // Empty read.
        @(negedge clk); host_ce_n = 1'b0; host_re_n = 1'b0;
        @(negedge clk); host_ce_n = 1'b1; host_re_n = 1'b1;
        chk("R9 empty read keeps rdata", int'(host_rdata), int'(last_rd));
        chk("R9 empty read no request", int'(dma_req), 0);

        // Random offsets and line lengths.
        for (int it = 0; it < 4; it++) begin
            set_offsets(int'($urandom_range(0, 3)), int'($urandom_range(0, 2)));
            frame(1, it[0]);
            chk("R5 frame finished", int'(frame_done), 1);
            drain("R1 R2 R3 random frame byte");
        end

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule